// File: doc/BRIEF.md
# Receive Squelch Qualifier

This block decides whether activity on a twisted-pair receive input is real data or noise. It watches two sampled comparator flags, one for the positive threshold and one for the negative threshold, plus a strobe that marks a detected end-of-frame idle pulse. The first threshold hit opens a qualification window. The window accepts the input only if the signal swings from one polarity to the other fast enough, and not too often. When the input is accepted, the squelch opens and the block asks the analog front end for the reduced hold threshold.

While open, the block closes the squelch again if neither flag is seen for a whole loss interval, or at once when the idle strobe arrives. A registered receive enable follows the open squelch. A level-select input picks between a standard and a long-reach trigger threshold. That choice is latched only while the block is squelched and idle, so it cannot move during qualification or reception. All time constants are cycle counts of the sampling clock. The defaults assume a 100 MHz clock: a 40-cycle window, a 12-cycle polarity swing limit, 9 swings to fail, and a 40-cycle loss interval.

Top module: `rx_squelch_qual`

## Requirements
- R1: During and right after reset, `squelch_off`, `thr_low_sel`, `thr_long_sel` and `rx_en` are all 0.
- R2: While squelched and idle, a cycle where exactly one of `pos_hit`/`neg_hit` is 1 starts a window of `WIN_CYC` further cycles. The verdict is taken in the last of them and is visible on `squelch_off` from the next cycle. A cycle with both flags high, or neither, does not start a window.
- R3: Acceptance needs at least one opposite-polarity sample whose distance in cycles from the latest earlier sample of the other polarity (the trigger included) is at most `GAP_MAX_CYC`.
- R4: Acceptance also needs fewer than `MAX_XING` polarity changes among the trigger and the window samples. `MAX_XING` or more changes reject.
- R5: A rejected window returns the block to the squelched idle state, where the next single-polarity sample starts a fresh window.
- R6: `thr_low_sel` is 1 exactly while `squelch_off` is 1.
- R7: While open, `LOSS_CYC` consecutive cycles with both flags at 0 close the squelch after the last of them. Any cycle with a flag high restarts that count.
- R8: `soi_det` high in an open or qualifying cycle returns the block to squelched idle from the next cycle. It has no effect while squelched and idle.
- R9: `rx_en` is registered. It rises one cycle after `squelch_off` rises and falls in the same cycle that `squelch_off` falls.
- R10: `thr_long_sel` takes the value `long_reach` had in each squelched-idle cycle. It holds its value while qualifying or open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pos_hit | input | 1 | Input above the positive threshold this sample |
| neg_hit | input | 1 | Input below the negative threshold this sample |
| soi_det | input | 1 | End-of-frame idle pulse detected |
| long_reach | input | 1 | Request for the lowered long-reach trigger threshold |
| squelch_off | output | 1 | Data judged valid (squelch open) |
| thr_low_sel | output | 1 | Select the reduced hold threshold |
| thr_long_sel | output | 1 | Latched long-reach trigger threshold select |
| rx_en | output | 1 | Registered receive enable |

## Verification
The assertions assume that all four inputs are already synchronous to the sampling clock. They also assume that `soi_det` may arrive in any state and for any number of cycles, and that `pos_hit` and `neg_hit` may be high together, a case the block treats as no hit. The stimulus drives every input half a cycle away from the active edge. Its random segments mix tones of many half-periods and duty cycles, bursts of random flag noise that often include both-high samples, quiet stretches, sparse idle strobes and level-select flips. This keeps the inputs within those assumptions while reaching both verdicts, both closing causes, and the freeze of the level select.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_QUAL = 2'd1,
    SQ_OPEN = 2'd2
  } sq_state_e;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_POS  = 2'd1,
    POL_NEG  = 2'd2
  } sq_pol_e;
endpackage

// File: rtl/sq_pol_class.sv
module sq_pol_class
  import sq_pkg::*;
(
  input  logic    pos_hit,
  input  logic    neg_hit,
  output sq_pol_e pol
);
  // A sample counts only when exactly one comparator reports.
  always_comb begin
    unique case ({pos_hit, neg_hit})
      2'b10:   pol = POL_POS;
      2'b01:   pol = POL_NEG;
      default: pol = POL_NONE;
    endcase
  end
endmodule

// File: rtl/sq_window_judge.sv
module sq_window_judge
  import sq_pkg::*;
#(
  parameter int WIN_CYC     = 40,
  parameter int GAP_MAX_CYC = 12,
  parameter int MAX_XING    = 9
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    active,
  input  sq_pol_e pol,
  output logic    win_last,
  output logic    verdict_ok
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int GW = $clog2(GAP_MAX_CYC + 1);
  localparam int XW = $clog2(MAX_XING + 1);
  localparam logic [WW-1:0] WIN_END = WW'(WIN_CYC - 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_MAX_CYC);
  localparam logic [XW-1:0] XING_TOP = XW'(MAX_XING);

  logic [WW-1:0] win_q, win_nx;
  logic [GW-1:0] gap_q, gap_nx;
  logic [XW-1:0] xing_q, xing_nx;
  logic          fast_q, fast_nx;
  sq_pol_e       last_q, last_nx;
  logic          have_pol, swing, swing_fast;

  always_comb begin
    have_pol   = (pol != POL_NONE);
    swing      = have_pol && (pol != last_q);
    // gap_q counts empty samples since the last valid one; distance is gap_q+1
    swing_fast = swing && (gap_q < GAP_TOP);
    xing_nx    = (swing && (xing_q != XING_TOP)) ? xing_q + 1'b1 : xing_q;
    fast_nx    = fast_q | swing_fast;
    last_nx    = have_pol ? pol : last_q;
    if (have_pol)              gap_nx = '0;
    else if (gap_q == GAP_TOP) gap_nx = gap_q;
    else                       gap_nx = gap_q + 1'b1;
    win_nx     = (win_q == WIN_END) ? win_q : win_q + 1'b1;
    win_last   = active && (win_q == WIN_END);
    verdict_ok = fast_nx && (xing_nx < XING_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      gap_q  <= '0;
      xing_q <= '0;
      fast_q <= 1'b0;
      last_q <= POL_NONE;
    end else if (start) begin
      win_q  <= '0;
      gap_q  <= '0;
      xing_q <= '0;
      fast_q <= 1'b0;
      last_q <= pol;
    end else if (active) begin
      win_q  <= win_nx;
      gap_q  <= gap_nx;
      xing_q <= xing_nx;
      fast_q <= fast_nx;
      last_q <= last_nx;
    end
  end
endmodule

// File: rtl/sq_quiet_timer.sv
module sq_quiet_timer #(
  parameter int LOSS_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  output logic expired
);
  localparam int LW = (LOSS_CYC > 1) ? $clog2(LOSS_CYC) : 1;
  localparam logic [LW-1:0] LOSS_END = LW'(LOSS_CYC - 1);

  logic [LW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  always_comb begin
    expired = run && !hit && (cnt_q == LOSS_END);
    cnt_en  = !run || hit || !expired;
    if (!run || hit) cnt_nx = '0;
    else             cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/rx_squelch_qual.sv
module rx_squelch_qual
  import sq_pkg::*;
#(
  parameter int WIN_CYC     = 40,
  parameter int GAP_MAX_CYC = 12,
  parameter int MAX_XING    = 9,
  parameter int LOSS_CYC    = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_hit,
  input  logic neg_hit,
  input  logic soi_det,
  input  logic long_reach,
  output logic squelch_off,
  output logic thr_low_sel,
  output logic thr_long_sel,
  output logic rx_en
);
  sq_state_e state_q, state_nx;
  sq_pol_e   pol;
  logic      start, qual_active, win_last, verdict_ok, quiet_expired;
  logic      rx_en_q, rx_en_nx, long_q, long_nx, long_en;

  sq_pol_class u_pol (
    .pos_hit (pos_hit),
    .neg_hit (neg_hit),
    .pol     (pol)
  );

  sq_window_judge #(
    .WIN_CYC     (WIN_CYC),
    .GAP_MAX_CYC (GAP_MAX_CYC),
    .MAX_XING    (MAX_XING)
  ) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .active     (qual_active),
    .pol        (pol),
    .win_last   (win_last),
    .verdict_ok (verdict_ok)
  );

  sq_quiet_timer #(
    .LOSS_CYC (LOSS_CYC)
  ) u_quiet (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == SQ_OPEN),
    .hit     (pos_hit | neg_hit),
    .expired (quiet_expired)
  );

  always_comb begin
    start       = (state_q == SQ_IDLE) && (pol != POL_NONE);
    qual_active = (state_q == SQ_QUAL);
    state_nx    = state_q;
    unique case (state_q)
      SQ_IDLE: if (start) state_nx = SQ_QUAL;
      SQ_QUAL: begin
        if (soi_det)       state_nx = SQ_IDLE;
        else if (win_last) state_nx = verdict_ok ? SQ_OPEN : SQ_IDLE;
      end
      SQ_OPEN: if (soi_det || quiet_expired) state_nx = SQ_IDLE;
      default: state_nx = SQ_IDLE;
    endcase
    // enable rises a cycle late, drops together with the squelch
    rx_en_nx = (state_nx == SQ_OPEN) && (state_q == SQ_OPEN);
    long_en  = (state_q == SQ_IDLE);
    long_nx  = long_reach;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rx_en_q <= 1'b0;
    end else begin
      state_q <= state_nx;
      rx_en_q <= rx_en_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       long_q <= 1'b0;
    else if (long_en) long_q <= long_nx;
  end

  assign squelch_off  = (state_q == SQ_OPEN);
  assign thr_low_sel  = (state_q == SQ_OPEN);
  assign thr_long_sel = long_q;
  assign rx_en        = rx_en_q;
endmodule

// File: rtl/sq_qual_checker.sv
module sq_qual_checker #(
  parameter int LOSS_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic pos_hit,
  input logic neg_hit,
  input logic soi_det,
  input logic squelch_off,
  input logic thr_long_sel,
  input logic rx_en
);
  logic [31:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      quiet_cnt <= '0;
    else if (!squelch_off)           quiet_cnt <= '0;
    else if (pos_hit || neg_hit)     quiet_cnt <= '0;
    else                             quiet_cnt <= quiet_cnt + 1;
  end

  p_rxen_within_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> squelch_off);

  p_rxen_late_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(squelch_off) |-> !rx_en);

  p_rxen_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (squelch_off && $past(squelch_off)) |-> rx_en);

  p_soi_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (squelch_off && soi_det) |=> !squelch_off);

  p_long_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squelch_off |=> $stable(thr_long_sel));

  p_quiet_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    squelch_off |-> (quiet_cnt < LOSS_CYC));
endmodule

bind rx_squelch_qual sq_qual_checker #(
  .LOSS_CYC (LOSS_CYC)
) u_sq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pos_hit      (pos_hit),
  .neg_hit      (neg_hit),
  .soi_det      (soi_det),
  .squelch_off  (squelch_off),
  .thr_long_sel (thr_long_sel),
  .rx_en        (rx_en)
);

// File: tb/tb_rx_squelch_qual.sv
module tb_rx_squelch_qual;
  localparam int WIN  = 40;
  localparam int GAP  = 12;
  localparam int MAXX = 9;
  localparam int LOSS = 40;
  localparam int MAX_CYCLES = 150000;

  logic clk, rst_n, pos_hit, neg_hit, soi_det, long_reach;
  logic squelch_off, thr_low_sel, thr_long_sel, rx_en;

  int total, bad, cyc;
  bit lr_cur;

  // reference model state
  int m_st, m_t0, m_lt, m_lp, m_x, m_quiet, mc;
  bit m_f, m_rx, m_long;

  rx_squelch_qual #(
    .WIN_CYC (WIN), .GAP_MAX_CYC (GAP), .MAX_XING (MAXX), .LOSS_CYC (LOSS)
  ) dut (
    .clk (clk), .rst_n (rst_n), .pos_hit (pos_hit), .neg_hit (neg_hit),
    .soi_det (soi_det), .long_reach (long_reach), .squelch_off (squelch_off),
    .thr_low_sel (thr_low_sel), .thr_long_sel (thr_long_sel), .rx_en (rx_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] model_out();
    return {m_st == 2, m_st == 2, m_long, m_rx};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  task automatic model_step(bit p, bit n, bit s, bit lr);
    int pl;
    int ns;
    bit hit;
    pl  = (p && !n) ? 1 : ((n && !p) ? 2 : 0);
    hit = p || n;
    ns  = m_st;
    if (m_st == 0) m_long = lr;
    case (m_st)
      0: if (pl != 0) begin
        ns = 1; m_t0 = mc; m_lt = mc; m_lp = pl; m_x = 0; m_f = 0;
      end
      1: if (s) ns = 0;
         else begin
           if (pl != 0) begin
             if (pl != m_lp) begin
               m_x++;
               if (mc - m_lt <= GAP) m_f = 1;
             end
             m_lp = pl; m_lt = mc;
           end
           if (mc - m_t0 == WIN) begin
             ns = (m_f && m_x < MAXX) ? 2 : 0;
             m_quiet = 0;
           end
         end
      default: if (s) ns = 0;
         else begin
           if (hit) m_quiet = 0; else m_quiet++;
           if (m_quiet == LOSS) ns = 0;
         end
    endcase
    m_rx = (ns == 2) && (m_st == 2);
    m_st = ns;
    mc++;
  endtask

  // one sampling cycle: drive at negedge, check just after the edge
  task automatic tick(bit p, bit n, bit s, bit lr);
    pos_hit = p; neg_hit = n; soi_det = s; long_reach = lr;
    model_step(p, n, s, lr);
    @(posedge clk);
    #1;
    chk("cycle-model", {squelch_off, thr_low_sel, thr_long_sel, rx_en}, model_out());
    @(negedge clk);
  endtask

  task automatic dchk(string req, logic act, logic exp);
    chk(req, {3'b000, act}, {3'b000, exp});
  endtask

  task automatic flush();
    tick(0, 0, 1, lr_cur);
    tick(0, 0, 0, lr_cur);
  endtask

  initial begin
    #(MAX_CYCLES * 4);
    bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    total = 0; bad = 0; cyc = 0; lr_cur = 0;
    m_st = 0; m_t0 = 0; m_lt = 0; m_lp = 0; m_x = 0; m_f = 0;
    m_quiet = 0; m_rx = 0; m_long = 0; mc = 0;
    rst_n = 1'b0; pos_hit = 0; neg_hit = 0; soi_det = 0; long_reach = 1;
    repeat (3) @(negedge clk);
    // R1: everything low in reset even with inputs active
    chk("R1 reset", {squelch_off, thr_low_sel, thr_long_sel, rx_en}, 4'b0000);
    rst_n = 1'b1;
    long_reach = 0;
    @(negedge clk);
    chk("R1 after reset", {squelch_off, thr_low_sel, thr_long_sel, rx_en}, 4'b0000);

    // R2 both flags high do not trigger: level select still follows
    flush();
    tick(1, 1, 0, 0);
    tick(0, 0, 0, 1);
    dchk("R2 both-high ignored", thr_long_sel, 1'b1);
    lr_cur = 1;

    // R4 eight swings of distance 1 accept; R2 decision timing
    flush();
    for (int k = 0; k <= WIN; k++) begin
      bit p, n;
      p = 0; n = 0;
      if (k <= 32) begin p = ((k / 4) % 2) == 0; n = !p; end
      tick(p, n, 0, lr_cur);
      if (k == WIN - 1) dchk("R2 still qualifying", squelch_off, 1'b0);
    end
    dchk("R4 eight swings open", squelch_off, 1'b1);
    dchk("R6 low threshold", thr_low_sel, 1'b1);
    dchk("R9 enable late", rx_en, 1'b0);
    tick(0, 0, 0, lr_cur);
    dchk("R9 enable follows", rx_en, 1'b1);
    for (int k = 0; k < LOSS - 2; k++) tick(0, 0, 0, lr_cur);
    dchk("R7 open before loss", squelch_off, 1'b1);
    tick(0, 0, 0, lr_cur);
    dchk("R7 closed after loss", squelch_off, 1'b0);
    dchk("R9 enable drops", rx_en, 1'b0);

    // R4 nine swings reject; R5 back to idle
    flush();
    for (int k = 0; k <= WIN; k++) begin
      bit p, n;
      p = 0; n = 0;
      if (k <= 36) begin p = ((k / 4) % 2) == 0; n = !p; end
      tick(p, n, 0, lr_cur);
    end
    dchk("R4 nine swings reject", squelch_off, 1'b0);
    lr_cur = !lr_cur;
    tick(0, 0, 0, lr_cur);
    dchk("R5 idle after reject", thr_long_sel, lr_cur);

    // R3 swing distance GAP+1 rejects, GAP accepts
    flush();
    for (int k = 0; k <= WIN; k++) tick(k == 0, k == GAP + 1, 0, lr_cur);
    dchk("R3 slow swing rejects", squelch_off, 1'b0);
    flush();
    for (int k = 0; k <= WIN; k++) tick(k == 0, k == GAP, 0, lr_cur);
    dchk("R3 swing at limit opens", squelch_off, 1'b1);
    tick(0, 0, 1, lr_cur);
    dchk("R8 idle pulse closes", squelch_off, 1'b0);
    dchk("R8 enable off", rx_en, 1'b0);

    // R8 idle pulse during qualification aborts it
    flush();
    for (int k = 0; k < 8; k++) tick(k < 4, k >= 4, 0, lr_cur);
    tick(0, 0, 1, lr_cur);
    lr_cur = !lr_cur;
    tick(0, 0, 0, lr_cur);
    dchk("R8 abort to idle", thr_long_sel, lr_cur);

    // R10 select frozen while qualifying and open
    flush();
    tick(0, 0, 0, 1);
    dchk("R10 idle follows", thr_long_sel, 1'b1);
    tick(1, 0, 0, 1);
    tick(0, 1, 0, 0);
    dchk("R10 frozen qualifying", thr_long_sel, 1'b1);
    for (int k = 2; k <= WIN; k++) tick(0, 0, 0, 0);
    dchk("R10 opened", squelch_off, 1'b1);
    tick(0, 0, 0, 0);
    dchk("R10 frozen open", thr_long_sel, 1'b1);
    tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
    dchk("R10 follows again", thr_long_sel, 1'b0);
    lr_cur = 0;

    // random segments checked against the model every cycle
    for (int seg = 0; seg < 700 && bad < 40; seg++) begin
      int mode, len, h, w;
      mode = $urandom_range(0, 3);
      len  = $urandom_range(10, 160);
      h    = $urandom_range(1, 16);
      w    = $urandom_range(1, h);
      if ($urandom_range(0, 7) == 0) lr_cur = !lr_cur;
      for (int c = 0; c < len; c++) begin
        bit p, n, s, on;
        p = 0; n = 0;
        s  = ($urandom_range(0, 199) == 0);
        on = ((c % h) < w);
        case (mode)
          0: ;
          1: begin p = on && ((c / h) % 2 == 0); n = on && ((c / h) % 2 == 1); end
          2: begin p = $urandom_range(0, 2) == 0; n = $urandom_range(0, 2) == 0; end
          default: begin
            p = on && ((c / h) % 2 == 0) && ($urandom_range(0, 3) != 0);
            n = on && ((c / h) % 2 == 1) && ($urandom_range(0, 3) != 0);
          end
        endcase
        tick(p, n, s, lr_cur);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule